// File: doc/BRIEF.md
# Power-Line Modem Host Receive Interface

This block connects the receive side of a power-line FSK modem to a host controller. The host picks one of four working modes with two level-sensitive select lines: transmit, receive, configuration read and configuration write. The block decodes these lines continuously into one-hot mode enables. Nothing is latched and nothing is edge-triggered.

In receive mode the block drives the serial receive data line from the demodulated bit. Synchronous access samples the bit on each rising edge of a recovered bit clock and passes that clock on to the host. Asynchronous access passes the bit straight through, and the host recovers its own bit timing. When no valid data is present, or the block is not receiving, the data line rests at an idle level. A static strap chooses that level: 0 for an SPI host and 1 for a UART host. The demodulated bit, the data-valid flag and the recovered clock all come from outside the system clock domain. Each of them passes through a two-flop synchronizer, and the recovered clock is used only as a sampled signal.

Top module: `plm_host_rx_if`

## Requirements
- R1: Mode decode from (cfg_sel, rx_dir): (0,1) gives reception (mode_rx), (0,0) gives transmission (mode_tx), (1,1) gives configuration read (mode_rd), (1,0) gives configuration write (mode_wr). The decode is combinational and follows the inputs in the same cycle.
- R2: Exactly one of mode_tx, mode_rx, mode_rd, mode_wr is high in every cycle out of reset.
- R3: Outside reception mode, rx_data holds the idle level. The idle level is 0 when host_uart=0 (SPI host) and 1 when host_uart=1 (UART host).
- R4: In reception mode, rx_data holds the idle level while the synchronized data_valid is 0. The synchronized value lags the input by two clock edges.
- R5: In synchronous access (sync_mode=1), the demodulated bit is captured on each rising edge of rec_clk. It appears on rx_data at the third system clock edge after the rec_clk and demod_bit inputs change.
- R6: In synchronous access, rx_data does not change between rising edges of rec_clk, even when demod_bit changes.
- R7: With sync_mode=1, host_clk follows rec_clk two system clock edges later. With sync_mode=0, host_clk stays 0.
- R8: In asynchronous access (sync_mode=0), rx_data equals demod_bit two system clock edges after demod_bit changes. No rec_clk activity is needed.
- R9: On entry into reception mode in synchronous access, rx_data shows the idle level until the next rec_clk rising edge has been captured. No bit captured before the entry appears.
- R10: During and just after reset (rst_n=0), host_clk is 0 and rx_data is at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel | input | 1 | Host select: 1 picks configuration access, 0 picks data |
| rx_dir | input | 1 | Host select: 1 picks the read/receive direction |
| host_uart | input | 1 | Static strap: 0 SPI host, 1 UART host |
| sync_mode | input | 1 | 1 selects synchronous access, 0 asynchronous |
| demod_bit | input | 1 | Demodulated bit, asynchronous |
| data_valid | input | 1 | Carrier/preamble qualifier, asynchronous |
| rec_clk | input | 1 | Recovered bit clock, asynchronous |
| mode_tx | output | 1 | Transmission mode enable |
| mode_rx | output | 1 | Reception mode enable |
| mode_rd | output | 1 | Configuration read enable |
| mode_wr | output | 1 | Configuration write enable |
| rx_data | output | 1 | Serial receive data to host |
| host_clk | output | 1 | Recovered bit clock to host |

## Verification
The latencies differ by result. The mode enables and the forced idle level that follows a mode change settle in the same cycle. The data_valid gate, the asynchronous data path and host_clk each lag their input by two system clock edges. A synchronously sampled bit appears on rx_data three edges after rec_clk rises. The bench drives every input one time unit after a rising edge and waits exactly that many edges. It then samples on the following falling edge, so each check lands on the first cycle in which the result is due. Hold checks sample several cycles after a disturbing change, to confirm that nothing moved.

// File: rtl/plm_rx_pkg.sv
// Shared types for the host receive interface.
// Assumes: the mode select encoding is {cfg_sel, rx_dir}.
package plm_rx_pkg;

    typedef enum logic [1:0] {
        MODE_TX = 2'b00,
        MODE_RX = 2'b01,
        MODE_WR = 2'b10,
        MODE_RD = 2'b11
    } plm_mode_e;

    // Idle line level for the selected host interface (0 SPI, 1 UART)
    function automatic logic idle_level(input logic uart_sel);
        return uart_sel;
    endfunction

endpackage

// File: rtl/plm_mode_decode.sv
// Continuous decode of the two level-sensitive host select lines into a
// mode code and one-hot enables. Assumes the select lines are quasi-static
// with respect to clk, since they are used without synchronization.
module plm_mode_decode
    import plm_rx_pkg::*;
(
    input  logic      cfg_sel,
    input  logic      rx_dir,
    output plm_mode_e mode,
    output logic      en_tx,
    output logic      en_rx,
    output logic      en_rd,
    output logic      en_wr
);

    // Map the select pair onto the mode code and its enables
    always_comb begin
        mode  = plm_mode_e'({cfg_sel, rx_dir});
        en_tx = 1'b0;
        en_rx = 1'b0;
        en_rd = 1'b0;
        en_wr = 1'b0;
        unique case (mode)
            MODE_TX: en_tx = 1'b1;
            MODE_RX: en_rx = 1'b1;
            MODE_RD: en_rd = 1'b1;
            MODE_WR: en_wr = 1'b1;
            default: en_tx = 1'b1;
        endcase
    end

endmodule

// File: rtl/plm_bit_sync.sv
// Multi-bit, multi-stage synchronizer for independent asynchronous
// single-bit signals. Assumes each bit is meaningful on its own, with no
// bus coherency between bits. Every stage resets to 0.
module plm_bit_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the asynchronous bit through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else if (STAGES == 1) chain <= d_async[b];
            else chain <= {chain[STAGES-2:0], d_async[b]};
        end

        assign q_sync[b] = chain[LAST];
    end

endmodule

// File: rtl/plm_rclk_edge.sv
// Rising-edge detector for the synchronized recovered bit clock.
// Assumes the recovered clock is several system clocks wide in each phase.
module plm_rclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rclk_s,
    output logic rise
);

    logic rclk_d;

    // Remember the previous sampled level
    always_ff @(posedge clk) begin
        if (!rst_n) rclk_d <= 1'b0;
        else rclk_d <= rclk_s;
    end

    assign rise = rclk_s & ~rclk_d;

endmodule

// File: rtl/plm_rx_path.sv
// Receive data path: synchronous capture register with an idle preload on
// mode entry, asynchronous pass-through, and idle forcing.
// Assumes bit_s and valid_s are already in the clk domain.
module plm_rx_path
    import plm_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic uart_sel,
    input  logic sync_sel,
    input  logic bit_s,
    input  logic valid_s,
    input  logic rise,
    output logic rx_out
);

    logic rx_q;
    logic rx_en_d;
    logic idle;
    logic entry;

    assign idle  = idle_level(uart_sel);
    assign entry = rx_en & ~rx_en_d;

    // Track reception mode one cycle back, to find mode entry
    always_ff @(posedge clk) begin
        if (!rst_n) rx_en_d <= 1'b0;
        else rx_en_d <= rx_en;
    end

    // Capture the bit on recovered-clock edges; preload idle on entry
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= 1'b0;
        else if (entry) rx_q <= idle;
        else if (rise) rx_q <= valid_s ? bit_s : idle;
    end

    // Select the visible line level
    always_comb begin
        if (!rx_en || !valid_s) rx_out = idle;
        else if (sync_sel) rx_out = rx_en_d ? rx_q : idle;
        else rx_out = bit_s;
    end

endmodule

// File: rtl/plm_host_rx_if.sv
// Top of the host receive interface. Decodes the host mode, synchronizes
// the demodulator bit, the data-valid qualifier and the recovered clock,
// and drives rx_data and host_clk. Assumes host_uart and sync_mode are
// static straps.
module plm_host_rx_if #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_sel,
    input  logic rx_dir,
    input  logic host_uart,
    input  logic sync_mode,
    input  logic demod_bit,
    input  logic data_valid,
    input  logic rec_clk,
    output logic mode_tx,
    output logic mode_rx,
    output logic mode_rd,
    output logic mode_wr,
    output logic rx_data,
    output logic host_clk
);
    import plm_rx_pkg::*;

    localparam int NSYNC = 3;

    plm_mode_e        mode;
    logic [NSYNC-1:0] sync_q;
    logic             bit_s;
    logic             valid_s;
    logic             rclk_s;
    logic             rclk_rise;

    plm_mode_decode u_dec (
        .cfg_sel (cfg_sel),
        .rx_dir  (rx_dir),
        .mode    (mode),
        .en_tx   (mode_tx),
        .en_rx   (mode_rx),
        .en_rd   (mode_rd),
        .en_wr   (mode_wr)
    );

    plm_bit_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({rec_clk, data_valid, demod_bit}),
        .q_sync  (sync_q)
    );

    assign bit_s   = sync_q[0];
    assign valid_s = sync_q[1];
    assign rclk_s  = sync_q[2];

    plm_rclk_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .rclk_s (rclk_s),
        .rise   (rclk_rise)
    );

    plm_rx_path u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (mode_rx),
        .uart_sel (host_uart),
        .sync_sel (sync_mode),
        .bit_s    (bit_s),
        .valid_s  (valid_s),
        .rise     (rclk_rise),
        .rx_out   (rx_data)
    );

    // Recovered clock to the host only in synchronous access
    assign host_clk = sync_mode & rclk_s;

endmodule

// File: rtl/plm_host_rx_chk.sv
// Assertion checker for plm_host_rx_if, attached by bind.
module plm_host_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic host_uart,
    input logic sync_mode,
    input logic mode_tx,
    input logic mode_rx,
    input logic mode_rd,
    input logic mode_wr,
    input logic rx_data,
    input logic host_clk,
    input logic bit_s,
    input logic valid_s,
    input logic rclk_rise
);

    // R2: one-hot mode enables
    p_onehot_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mode_tx, mode_rx, mode_rd, mode_wr}) == 1);

    // R3: idle level outside reception
    p_idle_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_rx |-> rx_data == host_uart);

    // R4: idle level while data is not valid
    p_idle_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rx && !valid_s) |-> rx_data == host_uart);

    // R6: in synchronous access the line moves only after a captured edge
    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rx && $past(mode_rx) && sync_mode && $past(sync_mode)
         && valid_s && $past(valid_s) && rx_data != $past(rx_data))
        |-> $past(rclk_rise));

    // R7: a host_clk rise coincides with a detected recovered-clock rise
    p_hclk_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && $past(sync_mode) && $rose(host_clk)) |-> rclk_rise);

    // R8: asynchronous access passes the synchronized bit
    p_async_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rx && !sync_mode && valid_s) |-> rx_data == bit_s);

endmodule

bind plm_host_rx_if plm_host_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_uart (host_uart),
    .sync_mode (sync_mode),
    .mode_tx   (mode_tx),
    .mode_rx   (mode_rx),
    .mode_rd   (mode_rd),
    .mode_wr   (mode_wr),
    .rx_data   (rx_data),
    .host_clk  (host_clk),
    .bit_s     (bit_s),
    .valid_s   (valid_s),
    .rclk_rise (rclk_rise)
);

// File: tb/tb_plm_host_rx_if.sv
`timescale 1ns/1ps
module tb_plm_host_rx_if;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_sel = 1'b0, rx_dir = 1'b1, host_uart = 1'b0, sync_mode = 1'b0;
    logic demod_bit = 1'b0, data_valid = 1'b0, rec_clk = 1'b0;
    logic mode_tx, mode_rx, mode_rd, mode_wr, rx_data, host_clk;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    plm_host_rx_if dut (.*);

    function automatic logic [3:0] exp_modes(logic sel, logic dir);
        // order {tx, rx, rd, wr}
        case ({sel, dir})
            2'b00:   return 4'b1000;
            2'b01:   return 4'b0100;
            2'b11:   return 4'b0010;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic exp_idle(logic uart);
        return uart;
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // sample on falling edge of the current cycle
    task automatic at_neg();
        @(negedge clk);
    endtask

    // full rec_clk rising edge with bit captured; returns after capture
    task automatic rec_pulse(logic b);
        demod_bit = b;
        rec_clk = 1'b1;
        step(3);
        at_neg();
        chk("R5 sync capture", {3'b0, rx_data}, {3'b0, b});
        demod_bit = ~b;
        step(4);
        at_neg();
        chk("R6 hold while rec high", {3'b0, rx_data}, {3'b0, b});
        rec_clk = 1'b0;
        step(4);
        at_neg();
        chk("R6 hold after rec fall", {3'b0, rx_data}, {3'b0, b});
        step(0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7538));
        // R10: reset state
        host_uart = 1'b1;
        rec_clk = 1'b1;
        sync_mode = 1'b1;
        step(4);
        at_neg();
        chk("R10 reset host_clk", {3'b0, host_clk}, 4'b0);
        chk("R10 reset rx_data", {3'b0, rx_data}, {3'b0, exp_idle(1'b1)});
        rst_n = 1'b1;
        rec_clk = 1'b0;
        step(1);
        at_neg();
        chk("R10 after reset rx_data", {3'b0, rx_data}, {3'b0, exp_idle(1'b1)});
        step(3);

        // R1/R2/R3: random mode decode and idle level outside reception
        for (int i = 0; i < 40; i++) begin
            logic s, d, u;
            s = 1'($urandom);
            d = 1'($urandom);
            u = 1'($urandom);
            cfg_sel = s;
            rx_dir = d;
            host_uart = u;
            data_valid = 1'b0;
            step(1);
            at_neg();
            chk("R1 mode decode", {mode_tx, mode_rx, mode_rd, mode_wr}, exp_modes(s, d));
            chk("R2 one-hot", 4'($countones({mode_tx, mode_rx, mode_rd, mode_wr})), 4'd1);
            if (!(s == 1'b0 && d == 1'b1))
                chk("R3 idle outside rx", {3'b0, rx_data}, {3'b0, exp_idle(u)});
        end

        // R8/R4: asynchronous pass-through with random bits
        step(0);
        cfg_sel = 1'b0;
        rx_dir = 1'b1;
        sync_mode = 1'b0;
        data_valid = 1'b1;
        step(3);
        for (int i = 0; i < 30; i++) begin
            logic b, u;
            b = 1'($urandom);
            u = 1'($urandom);
            host_uart = u;
            demod_bit = b;
            rec_clk = 1'($urandom);
            step(2);
            at_neg();
            chk("R8 async pass", {3'b0, rx_data}, {3'b0, b});
            chk("R7 host_clk low async", {3'b0, host_clk}, 4'b0);
        end
        step(0);
        host_uart = 1'b1;
        demod_bit = 1'b0;
        data_valid = 1'b0;
        step(2);
        at_neg();
        chk("R4 invalid forces idle UART", {3'b0, rx_data}, 4'b1);
        step(0);
        host_uart = 1'b0;
        demod_bit = 1'b1;
        step(2);
        at_neg();
        chk("R4 invalid forces idle SPI", {3'b0, rx_data}, 4'b0);

        // R5/R6/R7: synchronous access with random bits
        step(0);
        rec_clk = 1'b0;
        sync_mode = 1'b1;
        data_valid = 1'b1;
        host_uart = 1'b0;
        step(4);
        rec_clk = 1'b1;
        step(2);
        at_neg();
        chk("R7 host_clk follows", {3'b0, host_clk}, 4'b1);
        step(0);
        rec_clk = 1'b0;
        step(2);
        at_neg();
        chk("R7 host_clk falls", {3'b0, host_clk}, 4'b0);
        step(2);
        for (int i = 0; i < 20; i++) rec_pulse(1'($urandom));

        // R9: leave reception with a captured 1, return, expect idle
        rec_pulse(1'b1);
        rx_dir = 1'b0;
        step(1);
        at_neg();
        chk("R3 idle in tx", {3'b0, rx_data}, 4'b0);
        step(0);
        demod_bit = 1'b1;
        rx_dir = 1'b1;
        at_neg();
        chk("R9 entry cycle idle", {3'b0, rx_data}, 4'b0);
        step(3);
        at_neg();
        chk("R9 no stale bit", {3'b0, rx_data}, 4'b0);
        step(0);
        rec_pulse(1'b1);

        // R4: valid drop in synchronous access forces idle
        data_valid = 1'b0;
        step(2);
        at_neg();
        chk("R4 sync invalid idle", {3'b0, rx_data}, 4'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule